// File: doc/BRIEF.md
# Control Endpoint Receive Status Register

This block is an 8-bit status register for the control endpoint (endpoint 0) of a USB device function. When the endpoint-0 reception logic finishes a packet, it pulses a one-cycle completion strobe. On that cycle the register captures three things about the packet:

- the DATA0/DATA1 toggle,
- whether the token was a SETUP,
- how many data bytes arrived.

On the same edge it also notes whether the endpoint-0 transmit-complete flag was still pending. A pending flag means the IN transaction finished before this OUT or SETUP. Firmware uses that ordering bit to decide which endpoint-0 event to service first.

The CPU reads the register through a byte port. The read path is combinational and is gated by the address select. Writes are mostly ignored: only bit 5 has a write function, and a 1 there clears the ordering flag. Reset clears the ordering flag. The captured packet fields are deliberately left without reset, so they read as undefined until the first reception.

Top module: `ep0_rx_status`

## Requirements
- R1: Bit 7 reads the toggle sampled with `rx_done` (1 = DATA1, 0 = DATA0), from the edge where `rx_done` is high onward.
- R2: Bit 6 reads `rx_setup` as sampled on the `rx_done` cycle (1 = SETUP token).
- R3: Bits 3..0 read `rx_count` as sampled on the `rx_done` cycle.
- R4: Bits 7, 6 and 3..0 keep their values on every cycle without `rx_done`.
- R5: An `rx_done` cycle with `tx_pending` high sets the ordering flag, which reads on bit 5.
- R6: An `rx_done` cycle with `tx_pending` low leaves the ordering flag unchanged.
- R7: A write (`sel` and `wr_en` high) with `wdata[5]`=1 clears the ordering flag. A write with `wdata[5]`=0 leaves it unchanged.
- R8: When a clearing write and a setting reception fall on the same cycle, the flag ends up set.
- R9: Bit 4 always reads 0, and `rdata` is all zeros while `sel` is low.
- R10: Synchronous reset clears the ordering flag.
- R11: CPU writes never change bits 7, 6 or 3..0.
- R12: A change of `tx_pending` outside an `rx_done` cycle does not change the ordering flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle endpoint-0 reception-complete strobe |
| rx_toggle | input | 1 | Data toggle of the completed packet |
| rx_setup | input | 1 | Completed packet was a SETUP |
| rx_count | input | CNT_W (4) | Byte count of the completed packet |
| tx_pending | input | 1 | Endpoint-0 transmit flag still set |
| sel | input | 1 | Register address select |
| wr_en | input | 1 | CPU write enable |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |

## Verification
The assertions watch the following on every cycle:
- that the captured fields follow the strobe and otherwise stay stable,
- that a pending transmit at the strobe forces the ordering flag,
- that a clearing write that does not collide with a setting reception drops the flag,
- that unselected and unimplemented read bits stay zero.

Only the bench's directed scenarios can show the following:
- that the value read through the port matches the stimulus field by field,
- that writes of 0 to bit 5 and writes to other bits change nothing,
- that a late `tx_pending` is ignored until the next reception,
- that the set-wins collision resolves as required.

// File: rtl/ep0_stat_pkg.sv
package ep0_stat_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_TOG   = 7;
  localparam int BIT_SETUP = 6;
  localparam int BIT_TXF   = 5;
  localparam int BIT_RSV   = 4;
  localparam int CNT_MAX_W = 4;
endpackage

// File: rtl/ep0_cap_regs.sv
module ep0_cap_regs #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_done,
  input  logic             rx_toggle,
  input  logic             rx_setup,
  input  logic [CNT_W-1:0] rx_count,
  output logic             q_toggle,
  output logic             q_setup,
  output logic [CNT_W-1:0] q_count
);
  // Packet fields carry no reset: they are only meaningful after a reception.
  always_ff @(posedge clk) begin
    if (rx_done) begin
      q_toggle <= rx_toggle;
      q_setup  <= rx_setup;
      q_count  <= rx_count;
    end
  end

  // R1
  toggle_cap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> q_toggle == $past(rx_toggle));
  // R2
  setup_cap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> q_setup == $past(rx_setup));
  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> q_count == $past(rx_count));
  // R4
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_done |=> $stable({q_toggle, q_setup, q_count}));
endmodule

// File: rtl/ep0_order_flag.sv
module ep0_order_flag (
  input  logic clk,
  input  logic rst,
  input  logic rx_done,
  input  logic tx_pending,
  input  logic clr_req,
  output logic tx_first
);
  logic set_now;
  assign set_now = rx_done & tx_pending;

  // Set has priority over the software clear so no ordering event is lost.
  always_ff @(posedge clk) begin
    if (rst)          tx_first <= 1'b0;
    else if (set_now) tx_first <= 1'b1;
    else if (clr_req) tx_first <= 1'b0;
  end

  // R5 R8
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && tx_pending) |=> tx_first);
  // R7
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(rx_done && tx_pending)) |=> !tx_first);
  // R6 R12
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && !(rx_done && tx_pending)) |=> $stable(tx_first));
endmodule

// File: rtl/ep0_stat_rdmux.sv
module ep0_stat_rdmux
  import ep0_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             q_toggle,
  input  logic             q_setup,
  input  logic             tx_first,
  input  logic [CNT_W-1:0] q_count,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[BIT_TOG]   = q_toggle;
      rdata[BIT_SETUP] = q_setup;
      rdata[BIT_TXF]   = tx_first;
      for (int i = 0; i < CNT_W; i++) rdata[i] = q_count[i];
    end
  end

  // R9
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[BIT_RSV] == 1'b0);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |-> rdata == '0);
endmodule

// File: rtl/ep0_rx_status.sv
module ep0_rx_status
  import ep0_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_done,
  input  logic             rx_toggle,
  input  logic             rx_setup,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_pending,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int FIELD_W = CNT_W;

  logic             q_toggle, q_setup, tx_first, clr_req;
  logic [FIELD_W-1:0] q_count;
  logic             unused_wbits;

  initial begin
    if (CNT_W < 1 || CNT_W > CNT_MAX_W)
      $error("CNT_W must be between 1 and %0d", CNT_MAX_W);
  end

  assign clr_req      = sel & wr_en & wdata[BIT_TXF];
  assign unused_wbits = ^{wdata[7:6], wdata[4:0]};

  ep0_cap_regs #(.CNT_W(FIELD_W)) u_cap (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_toggle(rx_toggle),
    .rx_setup(rx_setup), .rx_count(rx_count),
    .q_toggle(q_toggle), .q_setup(q_setup), .q_count(q_count)
  );

  ep0_order_flag u_flag (
    .clk(clk), .rst(rst), .rx_done(rx_done), .tx_pending(tx_pending),
    .clr_req(clr_req), .tx_first(tx_first)
  );

  ep0_stat_rdmux #(.CNT_W(FIELD_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .q_toggle(q_toggle), .q_setup(q_setup),
    .tx_first(tx_first), .q_count(q_count), .rdata(rdata)
  );

  // R10
  rst_flag_chk: assert property (@(posedge clk)
    rst |=> !tx_first);
endmodule

// File: tb/ep0_rx_status_tb.sv
module ep0_rx_status_tb;
  logic clk = 0, rst = 1;
  logic rx_done = 0, rx_toggle = 0, rx_setup = 0, tx_pending = 0;
  logic [3:0] rx_count = 0;
  logic sel = 0, wr_en = 0;
  logic [7:0] wdata = 0, rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ep0_rx_status u_dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); sel = 1; #2; v = rdata; sel = 0;
  endtask

  task automatic rx(input logic t, input logic s, input logic [3:0] c, input logic p);
    @(negedge clk);
    rx_done = 1; rx_toggle = t; rx_setup = s; rx_count = c; tx_pending = p;
    @(negedge clk);
    rx_done = 0; rx_toggle = ~t; rx_setup = ~s; rx_count = ~c;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; wdata = d;
    @(negedge clk); sel = 0; wr_en = 0; wdata = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(v);
    chk("R10 flag after reset", v & 8'h30, 8'h00);
    #1; chk("R9 unselected read", rdata, 8'h00);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    rx(1, 1, 4'h8, 0); rd(v);
    chk("R1 R2 R3 setup DATA1 8B", v, 8'hC8);
    rx(0, 0, 4'h3, 0); rd(v);
    chk("R1 R2 R3 out DATA0 3B", v, 8'h03);
    rx(1, 0, 4'hF, 0); rd(v);
    chk("R3 R6 max count no flag", v, 8'h8F);
    repeat (5) @(negedge clk);
    rd(v);
    chk("R4 fields hold", v, 8'h8F);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    rx(0, 1, 4'h0, 1); rd(v);
    chk("R5 flag set zero bytes", v, 8'h60);
    rx(1, 0, 4'h2, 0); rd(v);
    chk("R6 flag kept", v, 8'hA2);
    wr(8'hDF); rd(v);
    chk("R7 R11 write of 0 to bit5", v, 8'hA2);
    wr(8'h20); rd(v);
    chk("R7 clear by write 1", v, 8'h82);
    wr(8'h20); rd(v);
    chk("R7 clear when already clear", v, 8'h82);
  endtask

  task automatic t_late_tx();
    logic [7:0] v;
    rx(0, 0, 4'h5, 0);
    @(negedge clk); tx_pending = 1;
    repeat (3) @(negedge clk);
    rd(v);
    chk("R12 late tx ignored", v, 8'h05);
    tx_pending = 0;
    wr(8'h00); rd(v);
    chk("R11 write zero no field change", v, 8'h05);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    @(negedge clk);
    rx_done = 1; rx_toggle = 1; rx_setup = 1; rx_count = 4'h7; tx_pending = 1;
    sel = 1; wr_en = 1; wdata = 8'hFF;
    @(negedge clk);
    rx_done = 0; tx_pending = 0; sel = 0; wr_en = 0; wdata = 0;
    rd(v);
    chk("R8 set wins over clear", v, 8'hE7);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(v);
    chk("R10 reset clears flag", v & 8'h30, 8'h00);
    chk("R4 fields kept across reset", v & 8'hCF, 8'hC7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_capture();
    t_flag();
    t_late_tx();
    t_collision();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule